// File: doc/BRIEF.md
# Two-Port Token Semaphore Bank

This block holds eight ownership tokens that two agents, called the left and the right port, use to claim shared resources. The tokens are held apart from any data storage. A port claims a token by writing a 0 to it and gives it up by writing a 1. It learns whether the claim succeeded by reading the token back. A port that holds a token sees 0 at that index, and the opposite port sees 1. A token that nobody holds reads 1 from both sides.

A port that tries to claim a held token does not take it. Its claim is kept pending instead. When the holder gives the token up, the pending claimant becomes the holder in the same clock edge. If both ports claim a free token in the same cycle, the left port wins and the right port's claim is kept pending. Each port has a select input for this bank and a separate memory-enable input. An access that raises both at once is refused.

The design is fully synchronous, with an active-high synchronous reset. Each port's read result is kept in an output register. That register changes only when the port performs a valid read.

Top module: `sem_token_bank`

## Requirements
- R1: The token index is taken from address bits [2:0]. All higher address bits have no effect on which token is accessed.
- R2: A write uses only data bit 0. Value 0 is a claim and value 1 is a release. Data bits [15:1] have no effect.
- R3: A read returns 0 to the port that holds the token and 1 to the other port. A free token reads 1 on both ports.
- R4: A write from the port that does not hold a token never changes who holds it. A claim (0) from that port is kept as pending.
- R5: When the holder releases a token and the other port has a claim pending, the other port holds the token from the next cycle on. With no claim pending, the token becomes free.
- R6: A valid read (select=1, memory enable=0, write=0, output enable=1) loads the port's output register at that clock edge with the token value copied onto all 16 data bits. The register keeps its value in every other cycle.
- R7: If both ports claim the same free token in the same cycle, the left port becomes the holder and the right port's claim is kept pending.
- R8: An access with both select and memory enable high is refused. It changes no token and no pending claim, and it does not load the output register.
- R9: A release written by a port that neither holds nor has claimed the token changes nothing. A release from a port with a pending claim cancels that claim.
- R10: Reset frees all eight tokens, clears all pending claims, and sets both output registers to all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l_sel | input | 1 | Left port token-bank select |
| l_mem_en | input | 1 | Left port memory enable; refuses the access when high together with select |
| l_we | input | 1 | Left port write strobe |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | 14 | Left port address; bits [2:0] pick the token |
| l_wdata | input | 16 | Left port write data; bit 0 used |
| l_rdata | output | 16 | Left port registered read value |
| r_sel | input | 1 | Right port token-bank select |
| r_mem_en | input | 1 | Right port memory enable; refuses the access when high together with select |
| r_we | input | 1 | Right port write strobe |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | 14 | Right port address; bits [2:0] pick the token |
| r_wdata | input | 16 | Right port write data; bit 0 used |
| r_rdata | output | 16 | Right port registered read value |

## Verification
A claim or release presented during a cycle takes effect at the next rising edge. A read presented in the following cycle therefore sees the new holder. A read loads the output register at the edge that ends the cycle in which the read is presented, and the new value stays visible until the next valid read. The bench changes inputs just after an edge and samples outputs 1 ns after the next edge. Every expected read value is compared one edge after its stimulus, and the hold cases are checked in cycles that carry no valid read.

// File: rtl/sem_pkg.sv
package sem_pkg;

    localparam int TOK_CNT   = 8;
    localparam int TOK_IDX_W = $clog2(TOK_CNT);

    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

    typedef struct packed {
        owner_e owner;
        logic   pend_l;
        logic   pend_r;
    } tok_state_t;

    typedef struct packed {
        logic req;
        logic rel;
    } tok_op_t;

    // Pending flag of one side after this cycle's write from that side.
    function automatic logic pend_next(input tok_op_t op, input logic pend);
        if (op.req)
            return 1'b1;
        else if (op.rel)
            return 1'b0;
        return pend;
    endfunction

endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec
    import sem_pkg::*;
#(
    parameter int N_TOK = TOK_CNT,
    localparam int IDX_W = $clog2(N_TOK)
) (
    input  logic             sel,
    input  logic             mem_en,
    input  logic             we,
    input  logic             oe,
    input  logic [IDX_W-1:0] idx,
    input  logic             wbit,
    output logic [N_TOK-1:0] req,
    output logic [N_TOK-1:0] rel,
    output logic             rd_en
);
    logic acc;
    logic wr;

    assign acc   = sel && !mem_en;
    assign wr    = acc && we;
    assign rd_en = acc && oe && !we;

    for (genvar t = 0; t < N_TOK; t++) begin : g_tok
        assign req[t] = wr && (idx == IDX_W'(t)) && !wbit;
        assign rel[t] = wr && (idx == IDX_W'(t)) &&  wbit;
    end

    always_comb begin
        assert (!(req != '0 && rel != '0)) else $error("AST_ONE_OP_KIND"); // R2
    end
endmodule

// File: rtl/sem_token_cell.sv
module sem_token_cell
    import sem_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  tok_op_t l_op,
    input  tok_op_t r_op,
    output logic    view_l,
    output logic    view_r
);
    tok_state_t cur, nxt;
    logic pl, pr;

    always_comb begin
        pl  = pend_next(l_op, cur.pend_l);
        pr  = pend_next(r_op, cur.pend_r);
        nxt = cur;
        case (cur.owner)
            OWN_NONE: begin
                nxt.pend_l = 1'b0;
                nxt.pend_r = 1'b0;
                if (l_op.req) begin
                    nxt.owner  = OWN_LEFT;
                    nxt.pend_r = r_op.req;
                end else if (r_op.req) begin
                    nxt.owner = OWN_RIGHT;
                end
            end
            OWN_LEFT: begin
                nxt.pend_l = 1'b0;
                if (l_op.rel) begin
                    nxt.owner  = pr ? OWN_RIGHT : OWN_NONE;
                    nxt.pend_r = 1'b0;
                end else begin
                    nxt.pend_r = pr;
                end
            end
            OWN_RIGHT: begin
                nxt.pend_r = 1'b0;
                if (r_op.rel) begin
                    nxt.owner  = pl ? OWN_LEFT : OWN_NONE;
                    nxt.pend_l = 1'b0;
                end else begin
                    nxt.pend_l = pl;
                end
            end
            default: begin
                nxt.owner  = OWN_NONE;
                nxt.pend_l = 1'b0;
                nxt.pend_r = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.owner  <= OWN_NONE;
            cur.pend_l <= 1'b0;
            cur.pend_r <= 1'b0;
        end else begin
            cur <= nxt;
        end
    end

    assign view_l = (cur.owner != OWN_LEFT);
    assign view_r = (cur.owner != OWN_RIGHT);

    AST_LEFT_HELD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cur.owner == OWN_LEFT && !l_op.rel) |=> (cur.owner == OWN_LEFT)) else $error("AST_LEFT_HELD_KEPT"); // R4
    AST_RIGHT_HELD_KEPT: assert property (@(posedge clk) disable iff (rst)
        (cur.owner == OWN_RIGHT && !r_op.rel) |=> (cur.owner == OWN_RIGHT)) else $error("AST_RIGHT_HELD_KEPT"); // R4
    AST_HANDOFF_TO_RIGHT: assert property (@(posedge clk) disable iff (rst)
        (cur.owner == OWN_LEFT && l_op.rel && cur.pend_r && !r_op.rel) |=> (cur.owner == OWN_RIGHT)) else $error("AST_HANDOFF_TO_RIGHT"); // R5
    AST_HANDOFF_TO_LEFT: assert property (@(posedge clk) disable iff (rst)
        (cur.owner == OWN_RIGHT && r_op.rel && cur.pend_l && !l_op.rel) |=> (cur.owner == OWN_LEFT)) else $error("AST_HANDOFF_TO_LEFT"); // R5
    AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (rst)
        (cur.owner == OWN_NONE && l_op.req && r_op.req) |=> (cur.owner == OWN_LEFT && cur.pend_r)) else $error("AST_TIE_LEFT_WINS"); // R7
    AST_FREE_NO_PEND: assert property (@(posedge clk) disable iff (rst)
        (cur.owner == OWN_NONE) |-> (!cur.pend_l && !cur.pend_r)) else $error("AST_FREE_NO_PEND"); // R10
    AST_VIEW_EXCL: assert property (@(posedge clk) disable iff (rst)
        (view_l || view_r)) else $error("AST_VIEW_EXCL"); // R3
endmodule

// File: rtl/sem_read_reg.sv
module sem_read_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              val,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '1;
        else if (rd_en)
            rdata <= {DATA_W{val}};
    end

    always_comb begin
        assert (rdata == '0 || rdata == '1 || $isunknown(rdata)) else $error("AST_RD_UNIFORM"); // R6
    end
endmodule

// File: rtl/sem_token_bank.sv
module sem_token_bank
    import sem_pkg::*;
#(
    parameter int N_TOK  = TOK_CNT,
    parameter int ADDR_W = 14,
    parameter int DATA_W = 16,
    localparam int IDX_W = $clog2(N_TOK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              l_sel,
    input  logic              l_mem_en,
    input  logic              l_we,
    input  logic              l_oe,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel,
    input  logic              r_mem_en,
    input  logic              r_we,
    input  logic              r_oe,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int NP = 2;

    logic              p_sel    [NP];
    logic              p_mem_en [NP];
    logic              p_we     [NP];
    logic              p_oe     [NP];
    logic [IDX_W-1:0]  p_idx    [NP];
    logic              p_wbit   [NP];
    logic [N_TOK-1:0]  p_req    [NP];
    logic [N_TOK-1:0]  p_rel    [NP];
    logic              p_rd_en  [NP];
    logic              p_val    [NP];
    logic [DATA_W-1:0] p_rdata  [NP];
    logic [N_TOK-1:0]  view     [NP];

    // Address bits above the index and data bits above bit 0 are not used.
    logic unused_bits;
    assign unused_bits = ^{l_addr[ADDR_W-1:IDX_W], r_addr[ADDR_W-1:IDX_W],
                           l_wdata[DATA_W-1:1], r_wdata[DATA_W-1:1]};

    assign p_sel[0] = l_sel;    assign p_sel[1] = r_sel;
    assign p_mem_en[0] = l_mem_en; assign p_mem_en[1] = r_mem_en;
    assign p_we[0] = l_we;      assign p_we[1] = r_we;
    assign p_oe[0] = l_oe;      assign p_oe[1] = r_oe;
    assign p_idx[0] = l_addr[IDX_W-1:0];
    assign p_idx[1] = r_addr[IDX_W-1:0];
    assign p_wbit[0] = l_wdata[0];
    assign p_wbit[1] = r_wdata[0];

    for (genvar p = 0; p < NP; p++) begin : g_port
        sem_port_dec #(.N_TOK(N_TOK)) dec_i (
            .sel    (p_sel[p]),
            .mem_en (p_mem_en[p]),
            .we     (p_we[p]),
            .oe     (p_oe[p]),
            .idx    (p_idx[p]),
            .wbit   (p_wbit[p]),
            .req    (p_req[p]),
            .rel    (p_rel[p]),
            .rd_en  (p_rd_en[p])
        );

        assign p_val[p] = view[p][p_idx[p]];

        sem_read_reg #(.DATA_W(DATA_W)) rreg_i (
            .clk   (clk),
            .rst   (rst),
            .rd_en (p_rd_en[p]),
            .val   (p_val[p]),
            .rdata (p_rdata[p])
        );
    end

    for (genvar t = 0; t < N_TOK; t++) begin : g_cell
        tok_op_t lop, rop;
        logic    vl, vr;
        assign lop.req = p_req[0][t];
        assign lop.rel = p_rel[0][t];
        assign rop.req = p_req[1][t];
        assign rop.rel = p_rel[1][t];

        sem_token_cell cell_i (
            .clk    (clk),
            .rst    (rst),
            .l_op   (lop),
            .r_op   (rop),
            .view_l (vl),
            .view_r (vr)
        );
        assign view[0][t] = vl;
        assign view[1][t] = vr;
    end

    assign l_rdata = p_rdata[0];
    assign r_rdata = p_rdata[1];

    AST_REJECT_HOLD_L: assert property (@(posedge clk) disable iff (rst)
        (l_sel && l_mem_en) |=> $stable(l_rdata)) else $error("AST_REJECT_HOLD_L"); // R8
    AST_REJECT_HOLD_R: assert property (@(posedge clk) disable iff (rst)
        (r_sel && r_mem_en) |=> $stable(r_rdata)) else $error("AST_REJECT_HOLD_R"); // R8
    AST_NO_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!l_sel && !r_sel) |=> ($stable(l_rdata) && $stable(r_rdata))) else $error("AST_NO_READ_HOLD"); // R6
endmodule

// File: tb/sem_token_bank_tb.sv
module sem_token_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        l_sel, l_mem_en, l_we, l_oe;
    logic [13:0] l_addr;
    logic [15:0] l_wdata;
    logic [15:0] l_rdata;
    logic        r_sel, r_mem_en, r_we, r_oe;
    logic [13:0] r_addr;
    logic [15:0] r_wdata;
    logic [15:0] r_rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sem_token_bank dut_i (
        .clk(clk), .rst(rst),
        .l_sel(l_sel), .l_mem_en(l_mem_en), .l_we(l_we), .l_oe(l_oe),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
        .r_sel(r_sel), .r_mem_en(r_mem_en), .r_we(r_we), .r_oe(r_oe),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata)
    );

    // Vector: {port(1=right), op(0 claim,1 release,2 read), idx[2:0], expected read bit}
    localparam int NV = 23;
    localparam logic [6:0] VEC [NV] = '{
        {1'b0, 2'd2, 3'd3, 1'b1}, {1'b1, 2'd2, 3'd3, 1'b1},
        {1'b0, 2'd0, 3'd3, 1'b0}, {1'b0, 2'd2, 3'd3, 1'b0}, {1'b1, 2'd2, 3'd3, 1'b1},
        {1'b1, 2'd0, 3'd3, 1'b0}, {1'b0, 2'd2, 3'd3, 1'b0}, {1'b1, 2'd2, 3'd3, 1'b1},
        {1'b0, 2'd1, 3'd3, 1'b0}, {1'b0, 2'd2, 3'd3, 1'b1}, {1'b1, 2'd2, 3'd3, 1'b0},
        {1'b0, 2'd0, 3'd3, 1'b0}, {1'b0, 2'd2, 3'd3, 1'b1}, {1'b1, 2'd2, 3'd3, 1'b0},
        {1'b1, 2'd1, 3'd3, 1'b0}, {1'b0, 2'd2, 3'd3, 1'b0}, {1'b1, 2'd2, 3'd3, 1'b1},
        {1'b0, 2'd1, 3'd3, 1'b0}, {1'b0, 2'd2, 3'd3, 1'b1}, {1'b1, 2'd2, 3'd3, 1'b1},
        {1'b1, 2'd0, 3'd3, 1'b0}, {1'b1, 2'd2, 3'd3, 1'b0}, {1'b0, 2'd2, 3'd3, 1'b1}
    };

    task automatic idle();
        l_sel = 0; l_mem_en = 0; l_we = 0; l_oe = 0; l_addr = '0; l_wdata = '0;
        r_sel = 0; r_mem_en = 0; r_we = 0; r_oe = 0; r_addr = '0; r_wdata = '0;
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_port(input bit rt, input logic ce, input logic we, input logic oe,
                            input logic [13:0] a, input logic [15:0] d);
        if (!rt) begin
            l_sel = 1; l_mem_en = ce; l_we = we; l_oe = oe; l_addr = a; l_wdata = d;
        end else begin
            r_sel = 1; r_mem_en = ce; r_we = we; r_oe = oe; r_addr = a; r_wdata = d;
        end
    endtask

    task automatic wr(input bit rt, input logic [13:0] a, input logic [15:0] d);
        set_port(rt, 1'b0, 1'b1, 1'b0, a, d);
        step();
        idle();
    endtask

    task automatic rd(input bit rt, input logic [13:0] a, input logic exp, input string tag);
        set_port(rt, 1'b0, 1'b0, 1'b1, a, '0);
        step();
        idle();
        check(tag, rt ? r_rdata : l_rdata, {16{exp}});
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        step(); step();
        rst = 0;
    endtask

    initial begin
        do_reset();
        // R10: output registers are all ones after reset, all tokens free
        check("R10 l_rdata after reset", l_rdata, 16'hFFFF);
        check("R10 r_rdata after reset", r_rdata, 16'hFFFF);
        for (int t = 0; t < 8; t++) begin
            rd(1'b0, 14'(t), 1'b1, "R10 left free");
            rd(1'b1, 14'(t), 1'b1, "R10 right free");
        end

        // Table: claim, pending, handoff and release sequence on one token (R3 R4 R5)
        for (int i = 0; i < NV; i++) begin
            logic [6:0] v;
            v = VEC[i];
            if (v[5:4] == 2'd2)
                rd(v[6], {11'd0, v[3:1]}, v[0], "R3 R4 R5 table");
            else
                wr(v[6], {11'd0, v[3:1]}, {15'd0, v[5:4] == 2'd1});
        end

        // R1: upper address bits ignored
        wr(1'b0, 14'h2AB6, 16'h0000);
        rd(1'b0, 14'h0006, 1'b0, "R1 left owns idx 6");
        rd(1'b1, 14'h3FFE, 1'b1, "R1 right sees idx 6 held");
        rd(1'b1, 14'h0005, 1'b1, "R1 idx 5 untouched");
        wr(1'b0, 14'h1006, 16'h0001);
        rd(1'b1, 14'h0006, 1'b1, "R1 idx 6 freed");

        // R2: only bit 0 matters
        wr(1'b0, 14'd1, 16'hFFFE);
        rd(1'b0, 14'd1, 1'b0, "R2 claim with FFFE");
        // R6: register holds across a write with no read
        wr(1'b0, 14'd1, 16'h0001);
        check("R6 hold after write", l_rdata, 16'h0000);
        step();
        check("R6 hold idle", l_rdata, 16'h0000);
        rd(1'b0, 14'd1, 1'b1, "R2 release with 0001");
        check("R6 all bits", l_rdata, 16'hFFFF);

        // R7: tie, left wins, right pending
        set_port(1'b0, 1'b0, 1'b1, 1'b0, 14'd4, 16'h0000);
        set_port(1'b1, 1'b0, 1'b1, 1'b0, 14'd4, 16'h0000);
        step(); idle();
        rd(1'b0, 14'd4, 1'b0, "R7 left wins tie");
        rd(1'b1, 14'd4, 1'b1, "R7 right loses tie");
        wr(1'b0, 14'd4, 16'h0001);
        rd(1'b1, 14'd4, 1'b0, "R7 right pending granted");
        wr(1'b1, 14'd4, 16'h0001);

        // R9: stray release and cancel of own pending claim
        wr(1'b0, 14'd2, 16'h0000);
        wr(1'b1, 14'd2, 16'h0001);
        rd(1'b0, 14'd2, 1'b0, "R9 stray release no effect");
        wr(1'b1, 14'd2, 16'h0000);
        wr(1'b1, 14'd2, 16'h0001);
        wr(1'b0, 14'd2, 16'h0001);
        rd(1'b1, 14'd2, 1'b1, "R9 cancelled claim not granted");
        rd(1'b0, 14'd2, 1'b1, "R9 token free after release");

        // R8: refused read keeps register, refused write changes nothing
        wr(1'b0, 14'd2, 16'h0000);
        rd(1'b0, 14'd2, 1'b0, "R8 setup left owns idx 2");
        set_port(1'b0, 1'b1, 1'b0, 1'b1, 14'd3, 16'h0000);
        step(); idle();
        check("R8 refused read holds", l_rdata, 16'h0000);
        wr(1'b0, 14'd2, 16'h0001);
        set_port(1'b1, 1'b1, 1'b1, 1'b0, 14'd5, 16'h0000);
        step(); idle();
        rd(1'b1, 14'd5, 1'b1, "R8 refused claim not taken");
        wr(1'b0, 14'd5, 16'h0000);
        wr(1'b0, 14'd5, 16'h0001);
        rd(1'b1, 14'd5, 1'b1, "R8 refused claim not pending");
        // R4: non-owner claim while held stays pending, not owner
        wr(1'b0, 14'd7, 16'h0000);
        wr(1'b1, 14'd7, 16'h0000);
        rd(1'b1, 14'd7, 1'b1, "R4 non-owner claim not granted");

        // R10: reset while held and pending
        do_reset();
        rd(1'b0, 14'd7, 1'b1, "R10 left free after reset");
        rd(1'b1, 14'd7, 1'b1, "R10 right free after reset");
        wr(1'b0, 14'd7, 16'h0000);
        wr(1'b0, 14'd7, 16'h0001);
        rd(1'b1, 14'd7, 1'b1, "R10 pending cleared by reset");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule